// File: doc/BRIEF.md
# Low-Side Channel Fault Supervisor

This block is the digital protection and diagnosis logic for a single low-side power switch. It drives the gate enable of the output transistor from an active-low on command, and it watches four comparator flags: overcurrent, overtemperature, drain below the ground-short reference, and load current below the open-load threshold. It runs on a slow internal oscillator clock. Every filter length is a parameter counted in clock cycles.

An overload, meaning overcurrent held past the short-circuit filter or overtemperature while the stage is on, switches the gate off at once. The gate then stays off until the command is released and applied again.

Ground shorts are looked for while the stage is commanded off. Open loads are looked for while it is on. Both checks share one spike filter, and that filter restarts whenever the command changes. An open load that is still present at switch-off is stored at the switch-off edge; this is the static case. An open load that passes the filter and then goes away while the channel is still on is stored at once; this is the sporadic case.

The failure register holds one 2-bit code under a priority rule. A readout path outside this block pulses a clear input after it takes the code. No flow control is needed at the edges, because every pin is a level or single-cycle control signal.

Top module: `lsd_fault_supervisor`

## Requirements
- R1: The gate enable is high only while the command (`cmd_n`, active low) is low. After the command changes, the gate follows three clock edges later: two synchroniser stages, then the gate register. After reset the gate is off until a low command has been seen.
- R2: Overcurrent that lasts more than `SC_CYC` consecutive synchronised cycles while the gate is on turns the gate off and stores code 01. A pulse of `SC_CYC` cycles or fewer has no effect.
- R3: Overtemperature while the gate is on turns the gate off at once and stores code 01.
- R4: After an overload shutdown the gate stays off while the command stays low. It turns on again only after the command goes high and then low.
- R5: With the command high, a drain-below-reference flag that lasts `DIAG_CYC` cycles stores code 00 (short to ground, channel off).
- R6: The shared diagnostic filter restarts on every change of the synchronised command. A condition interrupted by a command toggle must build up its full count again.
- R7: Static open load: a filtered low-load condition that is still present when the command goes high stores code 10 at that switch-off.
- R8: Sporadic open load: a filtered low-load condition that ends while the channel is still on stores code 10 at once, with no switch-off needed.
- R9: The priority order is overload 01, then short to ground 00, then open load 10, and 11 means no failure. A fault of higher rank overwrites a stored fault of lower rank. A fault of lower or equal rank leaves the stored code unchanged.
- R10: A one-cycle `reg_clear` sets the code to 11. If a fault is stored on the same edge as the clear, that fault's code is kept instead.
- R11: While `rst_n` is low (asynchronous) or `uv_reset` is high, the gate enable is 0 in the same cycle. The code becomes 11: at once for `rst_n`, and on the next edge for `uv_reset`. The overload latch is also released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| uv_reset | input | 1 | Undervoltage reset, active high, synchronous to clk |
| cmd_n | input | 1 | On command, active low; high means off |
| oc_flag | input | 1 | Overcurrent comparator, asynchronous |
| ot_flag | input | 1 | Overtemperature comparator, asynchronous |
| drain_low | input | 1 | Drain voltage below ground-short reference, asynchronous |
| load_low | input | 1 | Load current below open-load threshold, asynchronous |
| reg_clear | input | 1 | One-cycle pulse that clears the failure register after a readout |
| gate_en | output | 1 | Gate enable of the power transistor |
| fail_code | output | 2 | Stored failure code (11 none, 10 open load, 01 overload, 00 ground short) |

## Verification
The bench targets the corner cases a faulty design would get wrong. An overcurrent pulse of exactly the filter length must pass, while one a little longer must trip; an off-by-one counter either trips on the short pulse or misses the longer one. A ground short that is split by a brief on pulse must not be stored, which catches a filter that is not retriggered by the command. Open loads are driven both ways, once ending while on and once present at switch-off, to catch a design that handles only one of the two store paths. Priority is tested with lower faults arriving on top of higher codes. A clear is placed on the exact edge where an overtemperature trip is stored, so a design that lets the clear win would lose that fault.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [1:0] {
    FC_GND_SHORT = 2'b00,
    FC_OVERLOAD  = 2'b01,
    FC_OPEN_LOAD = 2'b10,
    FC_NONE      = 2'b11
  } fail_code_e;

  // Rank used for overwrite decisions: larger wins.
  function automatic logic [1:0] fc_rank(input fail_code_e c);
    case (c)
      FC_OVERLOAD:  fc_rank = 2'd3;
      FC_GND_SHORT: fc_rank = 2'd2;
      FC_OPEN_LOAD: fc_rank = 2'd1;
      default:      fc_rank = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int            W    = 1,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // Two-flop synchroniser; one pair per bit.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= INIT[i];
        q[i]      <= INIT[i];
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/lsd_overload_guard.sv
module lsd_overload_guard #(
  parameter int SC_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic on_cmd,
  input  logic oc,
  input  logic ot,
  output logic gate_q,
  output logic latched,
  output logic trip_ev
);
  localparam int CW = $clog2(SC_CYC + 1);

  logic [CW-1:0] sc_cnt;
  logic          armed;
  logic          trip_now;

  assign armed    = on_cmd && !latched;
  assign trip_now = armed && (ot || (oc && (sc_cnt == CW'(SC_CYC))));
  assign trip_ev  = trip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_cnt  <= '0;
      latched <= 1'b0;
      gate_q  <= 1'b0;
    end else if (srst) begin
      sc_cnt  <= '0;
      latched <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      if (!armed || !oc)
        sc_cnt <= '0;
      else if (sc_cnt != CW'(SC_CYC))
        sc_cnt <= sc_cnt + 1'b1;
      // Latch holds until the command is released.
      latched <= on_cmd && (latched || trip_now);
      gate_q  <= armed && !trip_now;
    end
  end
endmodule

// File: rtl/lsd_diag_filter.sv
module lsd_diag_filter #(
  parameter int DIAG_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic on_cmd,
  input  logic live,
  input  logic drain_low,
  input  logic load_low,
  output logic scg_ev,
  output logic ol_ev
);
  localparam int DW = $clog2(DIAG_CYC + 1);

  logic [DW-1:0] cnt;
  logic          on_d;
  logic          ol_pend;
  logic          cond;
  logic          steady;
  logic          qual;
  logic          sporadic;
  logic          static_off;

  assign steady     = (on_cmd == on_d);
  assign cond       = on_cmd ? (live && load_low) : drain_low;
  assign qual       = steady && cond && (cnt == DW'(DIAG_CYC));
  assign sporadic   = ol_pend && on_cmd && live && !load_low;
  assign static_off = ol_pend && on_d && !on_cmd;
  assign scg_ev     = qual && !on_cmd;
  assign ol_ev      = sporadic || static_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      on_d    <= 1'b0;
      ol_pend <= 1'b0;
    end else if (srst) begin
      cnt     <= '0;
      on_d    <= 1'b0;
      ol_pend <= 1'b0;
    end else begin
      on_d <= on_cmd;
      // Shared counter, retriggered by any command change.
      if (!steady || !cond)
        cnt <= '0;
      else if (cnt != DW'(DIAG_CYC))
        cnt <= cnt + 1'b1;
      if (ol_ev)
        ol_pend <= 1'b0;
      else if (qual && on_cmd)
        ol_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/lsd_fail_reg.sv
module lsd_fail_reg
  import lsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       clear,
  input  logic       ev_ovl,
  input  logic       ev_scg,
  input  logic       ev_ol,
  output fail_code_e code
);
  fail_code_e ev_code;
  logic       ev_any;

  always_comb begin
    ev_any  = 1'b1;
    ev_code = FC_NONE;
    if (ev_ovl)      ev_code = FC_OVERLOAD;
    else if (ev_scg) ev_code = FC_GND_SHORT;
    else if (ev_ol)  ev_code = FC_OPEN_LOAD;
    else             ev_any  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code <= FC_NONE;
    else if (srst)
      code <= FC_NONE;
    else if (clear)
      code <= ev_any ? ev_code : FC_NONE;
    else if (ev_any && (fc_rank(ev_code) > fc_rank(code)))
      code <= ev_code;
  end
endmodule

// File: rtl/lsd_fault_supervisor.sv
module lsd_fault_supervisor
  import lsd_pkg::*;
#(
  parameter int SC_CYC   = 5,
  parameter int DIAG_CYC = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_reset,
  input  logic       cmd_n,
  input  logic       oc_flag,
  input  logic       ot_flag,
  input  logic       drain_low,
  input  logic       load_low,
  input  logic       reg_clear,
  output logic       gate_en,
  output logic [1:0] fail_code
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;
  logic             s_cmd_n, s_oc, s_ot, s_drain, s_load;
  logic             on_cmd;
  logic             gate_q, latched, trip_ev;
  logic             scg_ev, ol_ev;
  fail_code_e       code;

  assign raw_in = {load_low, drain_low, ot_flag, oc_flag, cmd_n};
  assign {s_load, s_drain, s_ot, s_oc, s_cmd_n} = syn;
  assign on_cmd = !s_cmd_n;

  // Command resets to "off" so an undriven input never enables the gate.
  lsd_sync #(.W(NSYNC), .INIT(5'b00001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  lsd_overload_guard #(.SC_CYC(SC_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .srst(uv_reset), .on_cmd(on_cmd),
    .oc(s_oc), .ot(s_ot), .gate_q(gate_q), .latched(latched),
    .trip_ev(trip_ev)
  );

  lsd_diag_filter #(.DIAG_CYC(DIAG_CYC)) u_diag (
    .clk(clk), .rst_n(rst_n), .srst(uv_reset), .on_cmd(on_cmd),
    .live(!latched), .drain_low(s_drain), .load_low(s_load),
    .scg_ev(scg_ev), .ol_ev(ol_ev)
  );

  lsd_fail_reg u_freg (
    .clk(clk), .rst_n(rst_n), .srst(uv_reset), .clear(reg_clear),
    .ev_ovl(trip_ev), .ev_scg(scg_ev), .ev_ol(ol_ev), .code(code)
  );

  assign gate_en   = gate_q && rst_n && !uv_reset;
  assign fail_code = code;
endmodule

// File: rtl/lsd_fault_supervisor_chk.sv
module lsd_fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_reset,
  input logic       cmd_n,
  input logic       reg_clear,
  input logic       gate_en,
  input logic [1:0] fail_code
);
  a_r1_off_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_n, 3) |-> !gate_en);

  a_r1_on_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> !$past(cmd_n, 3));

  a_r11_uv_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_reset |-> !gate_en);

  a_r11_uv_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
    uv_reset |=> (fail_code == 2'b11));

  a_r9_overload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_code == 2'b01 && !reg_clear && !uv_reset) |=> (fail_code == 2'b01));
endmodule

bind lsd_fault_supervisor lsd_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_reset(uv_reset), .cmd_n(cmd_n),
  .reg_clear(reg_clear), .gate_en(gate_en), .fail_code(fail_code)
);

// File: tb/test_lsd_fault_supervisor.sv
module test_lsd_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int SC  = 5;
  localparam int DG  = 65;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_reset = 1'b0;
  logic       cmd_n = 1'b1;
  logic       oc_flag = 1'b0, ot_flag = 1'b0;
  logic       drain_low = 1'b0, load_low = 1'b0;
  logic       reg_clear = 1'b0;
  logic       gate_en;
  logic [1:0] fail_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic       gate;
    logic [1:0] code;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsd_fault_supervisor #(.SC_CYC(SC), .DIAG_CYC(DG)) i_lsd_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .uv_reset(uv_reset), .cmd_n(cmd_n),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .drain_low(drain_low),
    .load_low(load_low), .reg_clear(reg_clear),
    .gate_en(gate_en), .fail_code(fail_code)
  );

  // Monitor: compares one expected item per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (gate_en !== e.gate || fail_code !== e.code) begin
        errors++;
        $display("FAIL %s: gate=%b code=%b expected gate=%b code=%b",
                 e.tag, gate_en, fail_code, e.gate, e.code);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected under 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_state(input logic g, input logic [1:0] c, input string tag);
    exp_t e;
    e.gate = g; e.code = c; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    reg_clear = 1'b1; @(negedge clk); reg_clear = 1'b0;
  endtask

  task automatic retoggle();
    cmd_n = 1'b1; idle(8); cmd_n = 1'b0; idle(8);
  endtask

  initial begin
    idle(3);
    expect_state(1'b0, 2'b11, "R11 reset state");
    rst_n = 1'b1;
    idle(4);
    expect_state(1'b0, 2'b11, "R1 off while command high");

    cmd_n = 1'b0; idle(8);
    expect_state(1'b1, 2'b11, "R1 gate on");

    // R2: pulse of exactly SC cycles must not trip
    oc_flag = 1'b1; idle(SC); oc_flag = 1'b0; idle(8);
    expect_state(1'b1, 2'b11, "R2 short overcurrent ignored");
    oc_flag = 1'b1; idle(SC + 3); oc_flag = 1'b0; idle(2);
    expect_state(1'b0, 2'b01, "R2 long overcurrent trips");
    idle(10);
    expect_state(1'b0, 2'b01, "R4 stays off while command held");
    retoggle();
    expect_state(1'b1, 2'b01, "R4 re-enabled after toggle");

    pulse_clear(); idle(2);
    expect_state(1'b1, 2'b11, "R10 clear");

    ot_flag = 1'b1; idle(3); ot_flag = 1'b0; idle(2);
    expect_state(1'b0, 2'b01, "R3 overtemperature trip");
    retoggle(); pulse_clear(); idle(2);
    expect_state(1'b1, 2'b11, "R3 recovered and cleared");

    // R6: split ground short must not be stored
    cmd_n = 1'b1; idle(8);
    drain_low = 1'b1; idle(40);
    cmd_n = 1'b0; idle(3); cmd_n = 1'b1; idle(40);
    expect_state(1'b0, 2'b11, "R6 filter retriggered");
    idle(40);
    expect_state(1'b0, 2'b00, "R5 ground short stored");
    drain_low = 1'b0; idle(4);

    // R9: open load cannot overwrite ground short
    cmd_n = 1'b0; idle(8);
    load_low = 1'b1; idle(100); load_low = 1'b0; idle(8);
    expect_state(1'b1, 2'b00, "R9 open load below ground short");
    oc_flag = 1'b1; idle(SC + 5); oc_flag = 1'b0; idle(2);
    expect_state(1'b0, 2'b01, "R9 overload above ground short");
    cmd_n = 1'b1; idle(8);
    drain_low = 1'b1; idle(90); drain_low = 1'b0; idle(4);
    expect_state(1'b0, 2'b01, "R9 ground short below overload");
    pulse_clear(); idle(2);

    // R8 sporadic
    cmd_n = 1'b0; idle(8);
    load_low = 1'b1; idle(100);
    expect_state(1'b1, 2'b11, "R8 pending not yet stored");
    load_low = 1'b0; idle(8);
    expect_state(1'b1, 2'b10, "R8 sporadic open load");
    pulse_clear(); idle(2);

    // R7 static
    load_low = 1'b1; idle(100);
    expect_state(1'b1, 2'b11, "R7 held open load not stored while on");
    cmd_n = 1'b1; idle(8);
    expect_state(1'b0, 2'b10, "R7 static open load at switch-off");
    load_low = 1'b0;
    drain_low = 1'b1; idle(90); drain_low = 1'b0; idle(4);
    expect_state(1'b0, 2'b00, "R9 ground short over open load");

    // R10: clear on the same edge as an overtemperature store
    cmd_n = 1'b0; idle(8);
    ot_flag = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_clear = 1'b1; @(negedge clk); reg_clear = 1'b0;
    ot_flag = 1'b0; idle(2);
    expect_state(1'b0, 2'b01, "R10 fault kept over clear");
    retoggle();

    // R11 undervoltage
    uv_reset = 1'b1; @(negedge clk);
    expect_state(1'b0, 2'b11, "R11 undervoltage forces off and clears");
    uv_reset = 1'b0; idle(4);
    expect_state(1'b1, 2'b11, "R11 resumes after undervoltage");

    ot_flag = 1'b1; idle(3); ot_flag = 1'b0; retoggle();
    expect_state(1'b1, 2'b01, "R4 on again with stored overload");
    rst_n = 1'b0; @(negedge clk);
    expect_state(1'b0, 2'b11, "R11 external reset");

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule